// File: doc/BRIEF.md
# Memory-mapped SPI flash access sequencer

This block turns a CPU bus access that targets one chip-select window into a complete SPI flash transaction at byte level. When a request is accepted, the block decodes the control word of the addressed chip select and produces a sequence of bytes for a downstream SPI byte engine. In the addressed modes the sequence is an opcode, an address, optional dummy bytes and 1 to 4 data bytes. In user mode only data bytes are sent. The block assembles the read data and completes the bus access. Shifting bits onto the serial lines is left to the byte engine.

Each chip select has a 32-bit control word. Bits [1:0] hold the access mode: 0 is read, 1 is fast read, 2 is write and 3 is user. Bits [23:16] hold the opcode. Bit 2 is the chip-enable stop bit. Bits {14, 7:6} form the dummy selector and bit 28 is the dual address/data flag. A configuration word carries a write-enable bit for chip select n at bit 16+n. A per-chip-select input selects 4-byte addressing. A dummy word supplies, in its low byte, the value sent in every dummy slot.

Top module: `spi_flash_seq`

## Requirements
- R1: While reset is held and after it is released, with every chip select in a non-user mode: all chip-select outputs are high, spi_req_o is low and rsp_ready_o is low.
- R2: A read in read mode sends the opcode from control bits [23:16] first, or 0x03 when that field is zero, and then the address with its most-significant byte first.
- R3: The address phase is 4 bytes (req_addr_i[31:0]) when ext_addr_i[cs] is set and 3 bytes (req_addr_i[23:0]) otherwise.
- R4: In fast-read mode, the number of dummy bytes is 8 × {ctrl[14], ctrl[7:6]}, halved when ctrl[28] is set. Every dummy byte equals dummy_word_i[7:0].
- R5: Read and write modes send no dummy bytes, whatever value the dummy selector holds.
- R6: req_size_i is the byte count minus one. Data bytes move least-significant first: write data byte k is wdata[8k+7:8k]. Read data byte k is sent as 0x00, and the byte received for it lands in rsp_rdata_o[8k+7:8k]; unused upper bytes read as zero.
- R7: For a non-user access, the selected chip-select output is low for every byte of the transaction. It is high again in the cycle the response is given. At most one non-user chip select is low at any time.
- R8: In user mode, the chip-select output equals control bit 2 at all times, and an access moves only its data bytes.
- R9: A write to a chip select whose write-enable bit (cfg_i[16+cs]) is clear moves no byte and completes with rsp_err_o high.
- R10: Each of the following completes with rsp_err_o high and no byte sent: fast-read or write mode with a zero opcode, a write in read or fast-read mode, and a read in write mode.
- R11: spi_req_o and spi_tx_o hold steady until spi_ack_i. Bytes received during the opcode, address and dummy phases never reach rsp_rdata_o.
- R12: rsp_ready_o is a one-cycle pulse in the cycle after the last data byte is acknowledged, or in the cycle after acceptance for an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 32 | Configuration word; write enables at bit 16+cs |
| ctrl_i | input | 32*NUM_CS | Control word per chip select, cs n at bits [32n+31:32n] |
| ext_addr_i | input | NUM_CS | Per chip select 4-byte address enable |
| dummy_word_i | input | 32 | Dummy value; low byte used |
| req_valid_i | input | 1 | Bus request valid, held until rsp_ready_o |
| req_write_i | input | 1 | 1 write, 0 read |
| req_cs_i | input | CS_W | Target chip select |
| req_addr_i | input | 32 | Byte offset inside the window |
| req_size_i | input | 2 | Byte count minus one |
| req_wdata_i | input | 32 | Write data, little-endian |
| rsp_ready_o | output | 1 | Completion pulse |
| rsp_rdata_o | output | 32 | Read data, valid with rsp_ready_o |
| rsp_err_o | output | 1 | Access rejected, valid with rsp_ready_o |
| spi_cs_no | output | NUM_CS | Active-low chip selects |
| spi_req_o | output | 1 | Byte transfer request |
| spi_tx_o | output | 8 | Byte to send |
| spi_ack_i | input | 1 | Byte transfer done |
| spi_rx_i | input | 8 | Byte received |

## Verification
The read-mode sweep runs over both chip selects, both address widths, every size and both a zero and a non-zero opcode. It separates the default-opcode path from the programmed one and the 3-byte from the 4-byte address path. The dummy selector is left non-zero throughout to show that read mode ignores it. The fast-read sweep runs over all eight dummy selector values with and without the halving flag, so each possible dummy length and the dummy byte value are tied to their fields. Write, user and rejected accesses are compared as whole byte logs against the byte engine. A stalling acknowledge pattern separates held requests from advancing ones, and data received in every phase shows which bytes reach the read data.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FREAD = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } acc_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_DONE
  } phase_e;

  localparam int CTL_STOP_BIT = 2;
  localparam int CTL_DLO_LSB  = 6;
  localparam int CTL_DHI_BIT  = 14;
  localparam int CTL_OPC_LSB  = 16;
  localparam int CTL_DUAL_BIT = 28;
  localparam int CFG_WEN_LSB  = 16;
  localparam logic [7:0] OPC_DEFAULT = 8'h03;

  typedef struct packed {
    logic       user;
    logic       err;
    logic       wide;
    logic [5:0] n_dummy;
    logic [7:0] opcode;
  } plan_t;

endpackage

// File: rtl/spi_seq_decode.sv
module spi_seq_decode
  import spi_seq_pkg::*;
(
  input  logic [31:0] ctrl_word_i,
  input  logic        is_write_i,
  input  logic        writable_i,
  input  logic        ext_addr_i,
  output plan_t       plan_o
);

  acc_mode_e  mode;
  logic [7:0] raw_opc;
  logic [2:0] dsel;
  logic [5:0] dfull;
  logic [5:0] dcount;
  logic       bad;

  assign mode    = acc_mode_e'(ctrl_word_i[1:0]);
  assign raw_opc = ctrl_word_i[CTL_OPC_LSB +: 8];
  assign dsel    = {ctrl_word_i[CTL_DHI_BIT], ctrl_word_i[CTL_DLO_LSB +: 2]};
  assign dfull   = {dsel, 3'b000};
  assign dcount  = ctrl_word_i[CTL_DUAL_BIT] ? (dfull >> 1) : dfull;

  always_comb begin
    bad = 1'b0;
    if (is_write_i && !writable_i) begin
      bad = 1'b1;
    end else begin
      unique case (mode)
        MODE_READ:  bad = is_write_i;
        MODE_FREAD: bad = is_write_i || (raw_opc == 8'h00);
        MODE_WRITE: bad = !is_write_i || (raw_opc == 8'h00);
        MODE_USER:  bad = 1'b0;
        default:    bad = 1'b1;
      endcase
    end
  end

  always_comb begin
    plan_o         = '0;
    plan_o.user    = (mode == MODE_USER);
    plan_o.err     = bad;
    plan_o.wide    = ext_addr_i;
    plan_o.n_dummy = (mode == MODE_FREAD) ? dcount : 6'd0;
    plan_o.opcode  = ((mode == MODE_READ) && (raw_opc == 8'h00)) ? OPC_DEFAULT : raw_opc;
  end

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  plan_t      plan_i,
  input  logic [1:0] size_i,
  input  logic       spi_ack_i,
  output phase_e     phase_o,
  output logic [1:0] idx_o,
  output plan_t      plan_o,
  output logic       spi_req_o,
  output logic       fire_o
);

  phase_e     phase_q;
  logic [1:0] idx_q;
  logic [1:0] last_q;
  logic [5:0] dcnt_q;
  plan_t      plan_q;
  logic       fire;

  assign spi_req_o = (phase_q == PH_OPC) || (phase_q == PH_ADDR) ||
                     (phase_q == PH_DUMMY) || (phase_q == PH_DATA);
  assign fire      = spi_req_o && spi_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= 2'd0;
      last_q  <= 2'd0;
      dcnt_q  <= 6'd0;
      plan_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          plan_q <= plan_i;
          last_q <= size_i;
          idx_q  <= 2'd0;
          if (plan_i.err)       phase_q <= PH_DONE;
          else if (plan_i.user) phase_q <= PH_DATA;
          else                  phase_q <= PH_OPC;
        end
        PH_OPC: if (fire) begin
          phase_q <= PH_ADDR;
          idx_q   <= plan_q.wide ? 2'd3 : 2'd2;
        end
        PH_ADDR: if (fire) begin
          if (idx_q == 2'd0) begin
            if (plan_q.n_dummy != 6'd0) begin
              phase_q <= PH_DUMMY;
              dcnt_q  <= plan_q.n_dummy;
            end else begin
              phase_q <= PH_DATA;
            end
          end else begin
            idx_q <= idx_q - 2'd1;
          end
        end
        PH_DUMMY: if (fire) begin
          if (dcnt_q == 6'd1) begin
            phase_q <= PH_DATA;
            idx_q   <= 2'd0;
          end else begin
            dcnt_q <= dcnt_q - 6'd1;
          end
        end
        PH_DATA: if (fire) begin
          if (idx_q == last_q) phase_q <= PH_DONE;
          else                 idx_q   <= idx_q + 2'd1;
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign plan_o  = plan_q;
  assign fire_o  = fire;

  // R12
  ready_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE && !plan_q.err) |-> $past(fire));

  // R4
  dummy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DUMMY) |-> (dcnt_q != 6'd0 && dcnt_q <= plan_q.n_dummy));

endmodule

// File: rtl/spi_seq_bytes.sv
module spi_seq_bytes
  import spi_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        req_write_i,
  input  logic [31:0] req_addr_i,
  input  logic [31:0] req_wdata_i,
  input  logic [7:0]  dummy_byte_i,
  input  logic [7:0]  opcode_i,
  input  phase_e      phase_i,
  input  logic [1:0]  idx_i,
  input  logic        fire_i,
  input  logic [7:0]  spi_rx_i,
  output logic [7:0]  spi_tx_o,
  output logic [31:0] rdata_o
);

  logic        write_q;
  logic [31:0] addr_q;
  logic [31:0] wdata_q;
  logic [31:0] rdata_q;
  logic [4:0]  bsel;

  assign bsel = {idx_i, 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (start_i) begin
      write_q <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      rdata_q <= '0;
    end else if (fire_i && phase_i == PH_DATA && !write_q) begin
      rdata_q[bsel +: 8] <= spi_rx_i;
    end
  end

  always_comb begin
    unique case (phase_i)
      PH_OPC:   spi_tx_o = opcode_i;
      PH_ADDR:  spi_tx_o = addr_q[bsel +: 8];
      PH_DUMMY: spi_tx_o = dummy_byte_i;
      PH_DATA:  spi_tx_o = write_q ? wdata_q[bsel +: 8] : 8'h00;
      default:  spi_tx_o = 8'h00;
    endcase
  end

  assign rdata_o = rdata_q;

  // R11
  rx_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && phase_i != PH_DATA) |=> $stable(rdata_q));

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 2,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [31:0]          cfg_i,
  input  logic [32*NUM_CS-1:0] ctrl_i,
  input  logic [NUM_CS-1:0]    ext_addr_i,
  input  logic [31:0]          dummy_word_i,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [CS_W-1:0]      req_cs_i,
  input  logic [31:0]          req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic [31:0]          req_wdata_i,
  output logic                 rsp_ready_o,
  output logic [31:0]          rsp_rdata_o,
  output logic                 rsp_err_o,
  output logic [NUM_CS-1:0]    spi_cs_no,
  output logic                 spi_req_o,
  output logic [7:0]           spi_tx_o,
  input  logic                 spi_ack_i,
  input  logic [7:0]           spi_rx_i
);

  logic [31:0]       ctrl_sel;
  logic [NUM_CS-1:0] wen_vec;
  logic              start;
  plan_t             plan_new;
  plan_t             plan_q;
  phase_e            phase;
  logic [1:0]        idx;
  logic              fire;
  logic [CS_W-1:0]   cs_q;
  logic              busy_addr;
  logic [NUM_CS-1:0] sel_low;

  assign ctrl_sel = ctrl_i[{req_cs_i, 5'd0} +: 32];
  assign wen_vec  = cfg_i[CFG_WEN_LSB +: NUM_CS];
  assign start    = req_valid_i && (phase == PH_IDLE);

  spi_seq_decode u_decode (
    .ctrl_word_i (ctrl_sel),
    .is_write_i  (req_write_i),
    .writable_i  (wen_vec[req_cs_i]),
    .ext_addr_i  (ext_addr_i[req_cs_i]),
    .plan_o      (plan_new)
  );

  spi_seq_engine u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .plan_i    (plan_new),
    .size_i    (req_size_i),
    .spi_ack_i (spi_ack_i),
    .phase_o   (phase),
    .idx_o     (idx),
    .plan_o    (plan_q),
    .spi_req_o (spi_req_o),
    .fire_o    (fire)
  );

  spi_seq_bytes u_bytes (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .dummy_byte_i (dummy_word_i[7:0]),
    .opcode_i     (plan_q.opcode),
    .phase_i      (phase),
    .idx_i        (idx),
    .fire_i       (fire),
    .spi_rx_i     (spi_rx_i),
    .spi_tx_o     (spi_tx_o),
    .rdata_o      (rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cs_q <= '0;
    else if (start) cs_q <= req_cs_i;
  end

  assign busy_addr = !plan_q.user && (phase != PH_IDLE) && (phase != PH_DONE);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    logic [31:0] word;
    logic        is_user;
    assign word         = ctrl_i[32*g +: 32];
    assign is_user      = (word[1:0] == MODE_USER);
    assign spi_cs_no[g] = is_user ? word[CTL_STOP_BIT]
                                  : !(busy_addr && cs_q == CS_W'(g));
    assign sel_low[g]   = !is_user && !spi_cs_no[g];
  end

  assign rsp_ready_o = (phase == PH_DONE);
  assign rsp_err_o   = plan_q.err;

  // R11
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_tx_o)));

  // R7
  one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_low) <= 1);

  // R12
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |=> !rsp_ready_o);

  // R10
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ready_o && rsp_err_o) |-> !$past(spi_req_o));

endmodule

// File: tb/spi_flash_seq_test.sv
module spi_flash_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic [63:0] ctrl = '0;
  logic [1:0]  ext = '0;
  logic [31:0] dword = '0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [0:0]  cs = '0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0]  size = '0;
  logic        ready, err;
  logic [31:0] rdata;
  logic [1:0]  cs_n;
  logic        sreq, ack = 1'b0;
  logic [7:0]  tx, rx = '0;

  int errs = 0, checks = 0;
  logic [7:0] logb [0:127];
  logic [1:0] logc [0:127];
  int logn = 0, gk = 0, hold_bad = 0, pulse_bad = 0;
  logic [7:0] expb [0:127];
  int expn = 0, data0 = 0;
  logic       prev_wait = 1'b0;
  logic [7:0] prev_tx = '0;

  always #4 clk = ~clk;

  spi_flash_seq #(.NUM_CS(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .ctrl_i(ctrl), .ext_addr_i(ext),
    .dummy_word_i(dword), .req_valid_i(valid), .req_write_i(wr), .req_cs_i(cs),
    .req_addr_i(addr), .req_size_i(size), .req_wdata_i(wdata),
    .rsp_ready_o(ready), .rsp_rdata_o(rdata), .rsp_err_o(err),
    .spi_cs_no(cs_n), .spi_req_o(sreq), .spi_tx_o(tx),
    .spi_ack_i(ack), .spi_rx_i(rx)
  );

  // byte engine model with stalls
  initial forever begin
    @(negedge clk);
    if (prev_wait && (!sreq || tx != prev_tx)) hold_bad++;
    if (sreq && (gk % 4) != 3) begin
      ack = 1'b1;
      rx  = 8'(logn * 29 + 5);
      if (logn < 128) begin
        logb[logn] = tx;
        logc[logn] = cs_n;
      end
      logn++;
      prev_wait = 1'b0;
    end else begin
      ack = 1'b0;
      prev_wait = sreq;
      prev_tx = tx;
    end
    if (sreq) gk++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int mode, input logic [7:0] opc, input int d,
                                     input bit dual, input bit stop);
    logic [31:0] w = '0;
    w[1:0] = 2'(mode); w[2] = stop; w[7:6] = 2'(d & 3); w[14] = d[2];
    w[23:16] = opc; w[28] = dual;
    return w;
  endfunction

  task automatic access(input bit w, input int c, input logic [31:0] a, input int sz,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er);
    int n = 0;
    @(negedge clk);
    logn = 0;
    wr = w; cs = 1'(c); addr = a; size = 2'(sz - 1); wdata = wd; valid = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!ready && n < 2000);
    rd = rdata; er = err; valid = 1'b0;
    @(negedge clk);
    if (ready) pulse_bad++;
  endtask

  task automatic push(input logic [7:0] b);
    expb[expn] = b; expn++;
  endtask

  task automatic build(input logic [7:0] opc, input bit addressed, input bit wide,
                       input logic [31:0] a, input int nd, input logic [7:0] db,
                       input bit w, input logic [31:0] wd, input int sz);
    expn = 0;
    if (addressed) begin
      push(opc);
      if (wide) push(a[31:24]);
      push(a[23:16]); push(a[15:8]); push(a[7:0]);
      for (int i = 0; i < nd; i++) push(db);
    end
    data0 = expn;
    for (int k = 0; k < sz; k++) push(w ? wd[8*k +: 8] : 8'h00);
  endtask

  task automatic cmp_seq(input string req, input int c, input bit chk_cs);
    bit ok = (logn == expn);
    int bad = -1;
    for (int i = 0; i < expn && i < logn; i++)
      if (logb[i] !== expb[i] || (chk_cs && logc[i] !== 2'(~(1 << c)))) begin
        ok = 1'b0; if (bad < 0) bad = i;
      end
    if (bad >= 0) chk(ok, req, {24'h0, logb[bad]}, {24'h0, expb[bad]});
    else          chk(ok, req, 32'(logn), 32'(expn));
  endtask

  function automatic logic [31:0] exp_rd(input int sz);
    logic [31:0] v = '0;
    for (int k = 0; k < sz; k++) v[8*k +: 8] = 8'((data0 + k) * 29 + 5);
    return v;
  endfunction

  task automatic run_addr(input string req, input bit w, input int c, input bit wide,
                          input int sz, input logic [31:0] cw, input logic [7:0] eopc,
                          input int nd, input logic [31:0] a, input logic [31:0] wd);
    logic [31:0] rd; logic er;
    ctrl = '0; ctrl[32*c +: 32] = cw;
    ext = '0; ext[c] = wide;
    access(w, c, a, sz, wd, rd, er);
    build(eopc, 1'b1, wide, a, nd, dword[7:0], w, wd, sz);
    cmp_seq(req, c, 1'b1);
    chk(er == 1'b0, {req, " err"}, 32'(er), 0);
    // R6 R11: only data-phase bytes reach read data
    if (!w) chk(rd == exp_rd(sz), {req, " R6/R11 rdata"}, rd, exp_rd(sz));
    // R7
    chk(cs_n[c] == 1'b1, "R7 cs released", 32'(cs_n), 32'h3);
  endtask

  task automatic run_err(input string req, input bit w, input int c, input logic [31:0] cw);
    logic [31:0] rd; logic er;
    ctrl = '0; ctrl[32*c +: 32] = cw;
    access(w, c, 32'h0012_3456, 2, 32'hBEEF, rd, er);
    chk(er == 1'b1 && logn == 0, req, {31'(logn), er}, 32'h1);
  endtask

  initial begin : main
    logic [31:0] rd; logic er;
    repeat (3) @(negedge clk);
    // R1
    chk(cs_n == 2'b11 && !sreq && !ready, "R1 in reset", {29'h0, cs_n, sreq}, 32'h6);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 2'b11 && !sreq && !ready, "R1 after reset", {29'h0, cs_n, sreq}, 32'h6);

    // R2 R3 R5: read mode, dummy selector set but ignored
    dword = 32'h1234_56C3;
    for (int c = 0; c < 2; c++)
      for (int wd = 0; wd < 2; wd++)
        for (int sz = 1; sz <= 4; sz++)
          for (int o = 0; o < 2; o++)
            run_addr("R2/R3/R5 read seq", 1'b0, c, wd[0], sz,
                     mk(0, o ? 8'h13 : 8'h00, 5, 1'b0, 1'b1),
                     o ? 8'h13 : 8'h03, 0, 32'hC1A2B3D4 + 32'(c * 16 + sz), 0);

    // R4: fast read, every dummy selector, with and without halving
    for (int d = 0; d < 8; d++)
      for (int du = 0; du < 2; du++)
        for (int wd = 0; wd < 2; wd++) begin
          dword = 32'h5A00_00C3 + 32'(d);
          run_addr("R4 fast read seq", 1'b0, d % 2, wd[0], (d % 4) + 1,
                   mk(1, 8'h0B, d, du[0], 1'b0), 8'h0B, (d * 8) >> du,
                   32'h0F1E_2D3C + 32'(d), 0);
        end

    // R6 R5: write mode, little-endian data, no dummies
    cfg = 32'h0003_0000;
    for (int c = 0; c < 2; c++)
      for (int sz = 1; sz <= 4; sz++)
        run_addr("R6 write seq", 1'b1, c, c[0], sz, mk(2, 8'h02, 7, 1'b0, 1'b1),
                 8'h02, 0, 32'h0077_8899, 32'hA1B2C3D4 ^ 32'(sz));

    // R9
    cfg = 32'h0001_0000;
    run_err("R9 write dropped cs1", 1'b1, 1, mk(2, 8'h02, 0, 1'b0, 1'b1));
    cfg = 32'h0002_0000;
    run_err("R9 write dropped cs0", 1'b1, 0, mk(2, 8'h02, 0, 1'b0, 1'b1));
    run_err("R9 user write dropped", 1'b1, 0, mk(3, 8'h00, 0, 1'b0, 1'b0));

    // R10
    cfg = 32'h0003_0000;
    run_err("R10 fast read zero opc", 1'b0, 0, mk(1, 8'h00, 1, 1'b0, 1'b0));
    run_err("R10 write zero opc", 1'b1, 1, mk(2, 8'h00, 0, 1'b0, 1'b0));
    run_err("R10 read in write mode", 1'b0, 0, mk(2, 8'h02, 0, 1'b0, 1'b0));
    run_err("R10 write in read mode", 1'b1, 1, mk(0, 8'h03, 0, 1'b0, 1'b0));
    run_err("R10 write in fast mode", 1'b1, 0, mk(1, 8'h0B, 0, 1'b0, 1'b0));

    // R8: user mode
    for (int c = 0; c < 2; c++) begin
      ctrl = '0; ctrl[32*c +: 32] = mk(3, 8'h9F, 3, 1'b0, 1'b1);
      @(negedge clk);
      chk(cs_n[c] == 1'b1, "R8 user stop high", 32'(cs_n), 32'h3);
      ctrl[32*c + 2] = 1'b0;
      @(negedge clk);
      chk(cs_n[c] == 1'b0, "R8 user stop low", 32'(cs_n[c]), 0);
      access(1'b1, c, 32'h4455_6677, 3, 32'h00C0FFEE, rd, er);
      build(8'h00, 1'b0, 1'b0, 0, 0, 8'h00, 1'b1, 32'h00C0FFEE, 3);
      cmp_seq("R8 user write data only", c, 1'b1);
      chk(er == 1'b0 && cs_n[c] == 1'b0, "R8 user cs held", {30'h0, er, cs_n[c]}, 0);
      access(1'b0, c, 32'h4455_6677, 2, 0, rd, er);
      build(8'h00, 1'b0, 1'b0, 0, 0, 8'h00, 1'b0, 0, 2);
      cmp_seq("R8 user read data only", c, 1'b1);
      chk(rd == exp_rd(2), "R8 R6 user rdata", rd, exp_rd(2));
      ctrl[32*c + 2] = 1'b1;
      @(negedge clk);
      chk(cs_n[c] == 1'b1, "R8 user stop set again", 32'(cs_n), 32'h3);
    end

    // R11 R12
    chk(hold_bad == 0, "R11 request held until ack", 32'(hold_bad), 0);
    chk(pulse_bad == 0, "R12 single-cycle ready", 32'(pulse_bad), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule